// File: doc/BRIEF.md
# Ramp-Compare Conversion Sequencer for a Cell Bank

This block runs the digital side of a single-slope, time-encoded conversion of a bank of stored analog samples. When a start strobe is accepted, it releases one shared voltage ramp and starts one shared fast counter on the same clock edge. Each cell has its own comparator that watches the ramp against that cell's stored voltage. The block records the counter value in that cell's result when the comparator first changes state. The result is the elapsed ramp time, so it stands for the stored voltage.

All cells convert at the same time against the one counter, and each cell records its count on its own. Comparator bits are asynchronous to the fast clock. They pass through a synchronizer, and the latency that the synchronizer and edge detector add is taken out of the recorded value. The conversion window closes when the counter reaches full scale. Any cell that has not switched by then is pinned at the maximum code and flagged. A one-cycle done pulse closes the conversion. The ramp is then held in reset for a minimum guard time before another start is taken.

The ramp generator, the comparators and the sample storage are outside this block. The block sees them only through its ports.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, ramp_rst_o is 1, ramp_en_o is 0, done_o is 0, and every code and overflow bit is 0.
- R2: A start_i sampled high while the block is idle is accepted on that edge. From the next cycle, ramp_en_o is 1, ramp_rst_o is 0, and every code and overflow bit reads 0.
- R3: Number the clock edges from the accepting edge, which is edge 0. If a cell's comparator input is first sampled at its new level on edge m, with 1 <= m <= 510, that cell's code becomes m. The code for cell i sits at code_o[i*9 +: 9].
- R4: Only the first comparator transition after the start is recorded. Later toggles of the same comparator in the same conversion leave the code unchanged.
- R5: A cell whose first transition is sampled on edge 511 or later, or never, reports code 511 and has its overflow bit (ovf_o[i]) set. A captured code never sets the overflow bit.
- R6: done_o is high for exactly one cycle, the cycle after edge 512. ramp_en_o falls at the same time. Codes and overflow bits then hold until the next accepted start.
- R7: After done, the ramp stays in reset for 4 cycles. A start sampled on edges 1 to 4 after the done-raising edge is ignored. A start held high is accepted on edge 5.
- R8: A start strobe during a conversion has no effect: done still arrives after edge 512 of the first start.
- R9: Rising and falling comparator transitions both count, and each cell records its own time regardless of the other cells.
- R10: A transition recorded in the same cycle as the full-scale end (m = 510) keeps its code 510 and does not set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start request |
| cmp_i | input | 32 | Comparator outputs, one per cell, asynchronous |
| ramp_en_o | output | 1 | Ramp running |
| ramp_rst_o | output | 1 | Hold ramp discharged |
| code_o | output | 288 | Nine-bit time code per cell, cell i at [i*9 +: 9] |
| ovf_o | output | 32 | Per-cell overflow: no transition seen in the window |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
Two events can land in the same clock cycle. One is a cell's late capture; the other is the full-scale close, which pins every uncaptured cell to 511. The bench provokes this by timing one comparator so that it is sampled on edge 510 and another on edge 511. It then judges that the first keeps 510 with overflow clear and the second reports 511 with overflow set. A second overlap comes from start requests. These are held high from the very cycle done rises, and one is also injected mid-conversion. The bench counts the edges until the ramp actually starts, and checks that the injected request does not move done.

// File: rtl/wilk_pkg.sv
`timescale 1ns/1ps
package wilk_pkg;

    typedef enum logic [1:0] {
        ST_PRE  = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } wk_state_e;

    // Control strobes fanned out from the sequencer to every cell
    typedef struct packed {
        logic ramp_en;   // ramp running, counter advancing
        logic ramp_rst;  // ramp held discharged
        logic arm;       // start accepted this cycle: clear all cells
        logic fin;       // counter at full scale this cycle
    } wk_ctl_t;

    // Cycles between a sampled comparator change and the edge-detect pulse
    function automatic int unsigned wk_sync_lat(input int unsigned stages);
        return (stages > 0) ? stages - 1 : 0;
    endfunction

endpackage

// File: rtl/wilk_seq.sv
`timescale 1ns/1ps
module wilk_seq
    import wilk_pkg::*;
#(
    parameter int unsigned CW      = 9,
    parameter int unsigned RST_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output wk_ctl_t       ctl_o,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);
    localparam int unsigned TW = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] FULL = '1;
    localparam logic [TW-1:0] TLAST = TW'(RST_CYC - 1);

    wk_state_e     st;
    logic [TW-1:0] tmr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_PRE;
            tmr    <= '0;
            cnt    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st)
                ST_PRE: begin
                    cnt <= '0;
                    if (tmr == TLAST) begin
                        st  <= ST_IDLE;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_IDLE: begin
                    cnt <= '0;
                    if (start_i) st <= ST_RUN;
                end
                ST_RUN: begin
                    if (cnt == FULL) begin
                        st     <= ST_PRE;
                        tmr    <= '0;
                        cnt    <= '0;
                        done_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_PRE;
            endcase
        end
    end

    always_comb begin
        ctl_o.ramp_en  = (st == ST_RUN);
        ctl_o.ramp_rst = (st != ST_RUN);
        ctl_o.arm      = (st == ST_IDLE) && start_i;
        ctl_o.fin      = (st == ST_RUN) && (cnt == FULL);
    end

    assign cnt_o = cnt;

endmodule

// File: rtl/wilk_sync.sv
`timescale 1ns/1ps
module wilk_sync #(
    parameter int unsigned N      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cmp_i,
    output logic [N-1:0] edge_o
);
    // pipe[STAGES] is one extra flop used only for change detection
    logic [N-1:0] pipe [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= cmp_i;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign edge_o = pipe[STAGES-1] ^ pipe[STAGES];

endmodule

// File: rtl/wilk_cell.sv
`timescale 1ns/1ps
module wilk_cell
    import wilk_pkg::*;
#(
    parameter int unsigned CW  = 9,
    parameter int unsigned LAT = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  wk_ctl_t       ctl_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          edge_i,
    output logic [CW-1:0] code_o,
    output logic          ovf_o
);
    localparam logic [CW-1:0] LATV = CW'(LAT);

    logic got;
    logic hit;

    // A change pulse before LAT counts belongs to a level set before start
    assign hit = edge_i && (cnt_i > LATV);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_o <= '0;
            ovf_o  <= 1'b0;
            got    <= 1'b0;
        end else if (ctl_i.arm) begin
            code_o <= '0;
            ovf_o  <= 1'b0;
            got    <= 1'b0;
        end else if (ctl_i.ramp_en && !got) begin
            if (hit) begin
                code_o <= cnt_i - LATV;     // capture wins over full scale
                got    <= 1'b1;
            end else if (ctl_i.fin) begin
                code_o <= '1;
                ovf_o  <= 1'b1;
                got    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wilk_conv_ctrl.sv
`timescale 1ns/1ps
module wilk_conv_ctrl
    import wilk_pkg::*;
#(
    parameter int unsigned NCELL   = 32,
    parameter int unsigned CW      = 9,
    parameter int unsigned RST_CYC = 4,
    parameter int unsigned SYNC    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [NCELL-1:0]    cmp_i,
    output logic                ramp_en_o,
    output logic                ramp_rst_o,
    output logic [NCELL*CW-1:0] code_o,
    output logic [NCELL-1:0]    ovf_o,
    output logic                done_o
);
    localparam int unsigned LAT = wk_sync_lat(SYNC);

    wk_ctl_t          ctl;
    logic [CW-1:0]    cnt;
    logic [NCELL-1:0] edg;

    wilk_seq #(.CW(CW), .RST_CYC(RST_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .ctl_o   (ctl),
        .cnt_o   (cnt),
        .done_o  (done_o)
    );

    wilk_sync #(.N(NCELL), .STAGES(SYNC)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .cmp_i  (cmp_i),
        .edge_o (edg)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        wilk_cell #(.CW(CW), .LAT(LAT)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctl_i  (ctl),
            .cnt_i  (cnt),
            .edge_i (edg[i]),
            .code_o (code_o[i*CW +: CW]),
            .ovf_o  (ovf_o[i])
        );
    end

    assign ramp_en_o  = ctl.ramp_en;
    assign ramp_rst_o = ctl.ramp_rst;

endmodule

// File: rtl/wilk_conv_chk.sv
`timescale 1ns/1ps
module wilk_conv_chk #(
    parameter int unsigned NCELL = 32,
    parameter int unsigned CW    = 9
) (
    input logic                clk,
    input logic                rst,
    input logic                ramp_en_o,
    input logic                ramp_rst_o,
    input logic [NCELL*CW-1:0] code_o,
    input logic [NCELL-1:0]    ovf_o,
    input logic                done_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_DONE_ENDS_RAMP: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(ramp_en_o) && !ramp_en_o)); // R6

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (!ramp_en_o && !$past(ramp_en_o)) |-> $stable(code_o)); // R6

    AST_GUARD_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_en_o) |-> ($past(ramp_rst_o, 1) && $past(ramp_rst_o, 2)
                              && $past(ramp_rst_o, 3) && $past(ramp_rst_o, 4))); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_en_o) |-> (code_o == '0 && ovf_o == '0 && !ramp_rst_o)); // R2

    for (genvar i = 0; i < NCELL; i++) begin : g_cell_chk
        AST_OVF_MAX: assert property (@(posedge clk) disable iff (rst)
            ovf_o[i] |-> (&code_o[i*CW +: CW])); // R5

        AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (rst)
            (ramp_en_o && $past(ramp_en_o) && ($past(code_o[i*CW +: CW]) != '0))
            |-> $stable(code_o[i*CW +: CW])); // R4
    end

endmodule

bind wilk_conv_ctrl wilk_conv_chk #(.NCELL(NCELL), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ramp_en_o  (ramp_en_o),
    .ramp_rst_o (ramp_rst_o),
    .code_o     (code_o),
    .ovf_o      (ovf_o),
    .done_o     (done_o)
);

// File: tb/wilk_conv_ctrl_tb.sv
`timescale 1ns/1ps
module wilk_conv_ctrl_tb;
    localparam int NC   = 32;
    localparam int CW   = 9;
    localparam int NTV  = 8;
    // {cell, edge index of first sampled change}
    localparam int TV [NTV][2] = '{
        '{0, 1}, '{1, 2}, '{2, 3}, '{5, 100},
        '{9, 255}, '{17, 509}, '{30, 510}, '{31, 511}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [NC-1:0]   cmp = 32'hA5C3_0F96;
    logic            ramp_en, ramp_rst, done;
    logic [NC*CW-1:0] code;
    logic [NC-1:0]   ovf;

    int n_run  = 0;
    int n_fail = 0;
    int sched  [NC];
    int sched2 [NC];
    bit inj    = 1'b0;

    always #5 clk = ~clk;  // 100 MHz

    wilk_conv_ctrl u_dut (
        .clk(clk), .rst(rst), .start_i(start), .cmp_i(cmp),
        .ramp_en_o(ramp_en), .ramp_rst_o(ramp_rst),
        .code_o(code), .ovf_o(ovf), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_sched();
        for (int i = 0; i < NC; i++) begin
            sched[i]  = -1;
            sched2[i] = -1;
        end
    endtask

    // Raises start at a negedge, runs one conversion, returns at the
    // negedge where done is first seen.
    task automatic do_conv(input int exp_gap);
        int n = 0;
        int done_k = -1;
        start = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (n == 1 && exp_gap > 0) chk("R6 done lasts one cycle", int'(done), 0);
            if (exp_gap > 0 && n <= 4) chk("R7 ramp held in reset", int'(ramp_rst), 1);
        end while (!ramp_en && n < 20);
        start = 1'b0;
        if (exp_gap > 0) chk("R7 edges from done to accept", n, exp_gap);
        chk("R2 ramp reset released", int'(ramp_rst), 0);
        chk("R2 results cleared", (code == '0 && ovf == '0) ? 1 : 0, 1);
        for (int k = 0; k < 600; k++) begin
            if (k > 0) @(negedge clk);
            if (done) begin
                done_k = k;
                break;
            end
            for (int i = 0; i < NC; i++)
                if (sched[i] == k + 1 || sched2[i] == k + 1) cmp[i] = ~cmp[i];
            if (inj && k == 100) start = 1'b1;
            if (k == 101) start = 1'b0;
        end
        chk(inj ? "R8 mid-run start ignored, done edge" : "R6 done after edge 512",
            done_k, 512);
        chk("R6 ramp stops with done", int'(ramp_en), 0);
    endtask

    task automatic check_codes();
        for (int i = 0; i < NC; i++) begin
            int m    = sched[i];
            int ec   = (m >= 1 && m <= 510) ? m : 511;
            int eo   = (ec == 511) ? 1 : 0;
            string r;
            if (m == 510)         r = "R10 capture on full-scale cycle";
            else if (ec == 511)   r = "R5 overflow code";
            else if (sched2[i] > 0) r = "R4 later toggle ignored";
            else if (i < 2)       r = "R9 rise/fall polarity";
            else                  r = "R3 captured time";
            chk(r, int'(ovf[i]) * 1000 + int'(code[i*CW +: CW]), eo * 1000 + ec);
        end
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clear_sched();
        repeat (5) @(negedge clk);
        chk("R1 ramp reset in reset", int'(ramp_rst), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ramp reset", int'(ramp_rst), 1);
        chk("R1 ramp off", int'(ramp_en), 0);
        chk("R1 done low", int'(done), 0);
        chk("R1 results zero", (code == '0 && ovf == '0) ? 1 : 0, 1);

        // Table-driven conversion: mixed cells, others never switch
        for (int t = 0; t < NTV; t++) sched[TV[t][0]] = TV[t][1];
        do_conv(0);
        check_codes();

        // Directed: repeated toggles, mid-run start, start held from done
        clear_sched();
        sched[3] = 40;  sched2[3] = 60;
        sched[4] = 10;  sched2[4] = 11;
        sched[7] = 200;
        inj = 1'b1;
        do_conv(5);
        inj = 1'b0;
        check_codes();

        // Directed: no cell switches, all overflow, then results hold
        clear_sched();
        do_conv(5);
        check_codes();
        repeat (3) @(negedge clk);
        chk("R6 codes hold after done", int'(code[0 +: CW]), 511);
        chk("R6 overflow holds after done", (ovf == '1) ? 1 : 0, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule